// File: doc/BRIEF.md
# Ellipse Outline Pixel Generator

This block turns a single drawing request into the stream of pixel coordinates that trace the outline of an axis-aligned ellipse. A request carries a centre point, a horizontal radius, a vertical radius and a colour. It is captured on a start pulse. The block then walks the outline using only integer arithmetic and hands out one point per accepted handshake on a plotter-style port: x, y, colour and a write strobe, with a ready input for backpressure.

A circle is requested through the same engine. Circle mode takes the horizontal radius for both axes, so circles need no separate logic. The outline is not produced by mirroring eight octants on every step. It is drawn as four quadrant arcs in a fixed order, one after another. Each arc starts on the vertical axis and ends on the horizontal axis.

No point is clipped. Coordinates wrap modulo 4096, and screen limits are applied by whatever sits downstream. A done flag tells the requester that the last point has been accepted.

Top module: `ellipse_outline`

## Requirements
- R1: After reset, pixValid and done are both 0.
- R2: A run emits four arcs in the order top-left, top-right, bottom-left, bottom-right (quadrant index 0..3). For an arc offset (dx, dy), the point is (cx-dx, cy-dy), (cx+dx, cy-dy), (cx-dx, cy+dy) and (cx+dx, cy+dy) respectively.
- R3: With ry > 0, each arc is the integer two-region midpoint walk from offset (0, ry).
  - Region 1 emits while 2·ry²·x < 2·rx²·y. Each step increments x, and decrements y when the decision term (scaled by 4, starting at 4ry²−4rx²ry+rx²) is not negative.
  - Region 2 re-seeds the term as ry²(2x+1)²+4rx²(y−1)²−4rx²ry². It then emits while y ≥ 0. Each step decrements y, and increments x when the term is not positive.
- R4: When circleMode is 1 at start, the vertical radius is taken from radX and radY is ignored.
- R5: A zero vertical radius makes each arc the straight run of offsets (0,0) to (rx,0). A zero horizontal radius with a nonzero vertical radius makes each arc the run (0,ry) down to (0,0).
- R6: When both radii are zero, the run emits exactly one point, the centre.
- R7: While pixValid is 1 and pixReady is 0, pixValid stays 1 and pixX, pixY and pixColor hold their values.
- R8: Every emitted point carries the colour latched at start. Changes on the centre, radius, colour and circleMode inputs during a run have no effect on that run.
- R9: start is acted on only when no run is in progress. This includes the cycle in which the final point of a run is accepted.
- R10: done goes to 0 when a start is accepted, goes to 1 on the clock edge that accepts the final point, and stays 1 until the next accepted start. pixValid is 0 whenever done is 1.
- R11: Coordinates are 12 bits and wrap modulo 4096. Points beyond the screen are emitted and not dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse that captures the parameters |
| circleMode | input | 1 | 1 = use radX for both radii |
| centerX | input | 12 | Centre x |
| centerY | input | 12 | Centre y |
| radX | input | 12 | Horizontal radius |
| radY | input | 12 | Vertical radius |
| color | input | 8 | Colour for every point of the run |
| pixX | output | 12 | Point x |
| pixY | output | 12 | Point y |
| pixColor | output | 8 | Point colour |
| pixValid | output | 1 | Write strobe: a point is offered |
| pixReady | input | 1 | Downstream accepts the offered point |
| done | output | 1 | Last point of the run accepted |

## Verification
The interesting coincidence is a fresh start request arriving in the very cycle that the final point of a run is accepted. At that edge the controller is still busy, so the request must be dropped. The bench provokes this by raising start, with new parameters, exactly when it sees the last expected point offered with ready high. It then expects done to rise, pixValid to stay low for several cycles and no extra point to appear. A second case raises start with altered inputs in the middle of a run, while ready toggles pseudo-randomly. Every accepted point is compared against a behavioural integer model of the four-arc walk.

// File: rtl/ellipse_pkg.sv
package ellipse_pkg;

  // Strobes from the controller to the datapath
  typedef struct packed {
    logic load;
    logic quadInit;
    logic r2Init;
    logic stepR1;
    logic stepR2;
    logic stepRun;
  } ctlStrobes_t;

  // Status from the datapath back to the controller
  typedef struct packed {
    logic r1Active;
    logic yZero;
    logic xAtRx;
    logic ryZero;
    logic bothZero;
  } dpStatus_t;

  typedef enum logic [2:0] {
    S_IDLE, S_QINIT, S_R1, S_R2INIT, S_R2, S_RUN
  } genState_t;

endpackage

// File: rtl/ellipse_dp.sv
module ellipse_dp
  import ellipse_pkg::*;
#(
  parameter int CW   = 12,
  parameter int COLW = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctlStrobes_t     cs,
  input  logic [1:0]      quad,
  input  logic            circleMode,
  input  logic [CW-1:0]   centerX,
  input  logic [CW-1:0]   centerY,
  input  logic [CW-1:0]   radX,
  input  logic [CW-1:0]   radY,
  input  logic [COLW-1:0] color,
  output dpStatus_t       stat,
  output logic [CW-1:0]   pixX,
  output logic [CW-1:0]   pixY,
  output logic [COLW-1:0] pixColor
);
  // rx^2 * ry^2 and ry^2*(2x+1)^2 need about 4*CW+2 bits
  localparam int DW = 4*CW + 8;
  localparam logic signed [DW-1:0] ONE = 1;

  logic [CW-1:0]   cX, cY, rX, rY, offX, offY;
  logic [COLW-1:0] col;
  logic signed [DW-1:0] p, px, py;
  logic signed [DW-1:0] rxW, ryW, xW, yW, rx2, ry2, pxN, pyN, twoXp1, yM1;

  always_comb begin
    rxW    = $signed({{(DW-CW){1'b0}}, rX});
    ryW    = $signed({{(DW-CW){1'b0}}, rY});
    xW     = $signed({{(DW-CW){1'b0}}, offX});
    yW     = $signed({{(DW-CW){1'b0}}, offY});
    rx2    = rxW * rxW;
    ry2    = ryW * ryW;
    pxN    = px + (ry2 <<< 1);
    pyN    = py - (rx2 <<< 1);
    twoXp1 = (xW <<< 1) + ONE;
    yM1    = yW - ONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cX <= '0; cY <= '0; rX <= '0; rY <= '0; col <= '0;
      offX <= '0; offY <= '0; p <= '0; px <= '0; py <= '0;
    end else begin
      if (cs.load) begin
        cX  <= centerX;
        cY  <= centerY;
        rX  <= radX;
        rY  <= circleMode ? radX : radY;
        col <= color;
      end
      if (cs.quadInit) begin
        offX <= '0;
        offY <= rY;
        px   <= '0;
        py   <= (rx2 * ryW) <<< 1;
        p    <= (ry2 <<< 2) - ((rx2 * ryW) <<< 2) + rx2;
      end
      if (cs.r2Init)
        p <= ry2 * twoXp1 * twoXp1 + ((rx2 * yM1 * yM1) <<< 2) - ((rx2 * ry2) <<< 2);
      if (cs.stepR1) begin
        offX <= offX + 1'b1;
        px   <= pxN;
        if (p < 0) p <= p + ((ry2 + pxN) <<< 2);
        else begin
          offY <= offY - 1'b1;
          py   <= pyN;
          p    <= p + ((ry2 + pxN - pyN) <<< 2);
        end
      end
      if (cs.stepR2) begin
        offY <= offY - 1'b1;
        py   <= pyN;
        if (p > 0) p <= p + ((rx2 - pyN) <<< 2);
        else begin
          offX <= offX + 1'b1;
          px   <= pxN;
          p    <= p + ((rx2 - pyN + pxN) <<< 2);
        end
      end
      if (cs.stepRun) offX <= offX + 1'b1;
    end
  end

  always_comb begin
    stat.r1Active = px < py;
    stat.yZero    = offY == '0;
    stat.xAtRx    = offX == rX;
    stat.ryZero   = rY == '0;
    stat.bothZero = (rX == '0) && (rY == '0);
  end

  // quad[0]: right half, quad[1]: bottom half
  assign pixX     = quad[0] ? cX + offX : cX - offX;
  assign pixY     = quad[1] ? cY + offY : cY - offY;
  assign pixColor = col;

  // R3: within an arc the offset x never shrinks and the offset y never grows
  p_offx_mono_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cs.stepR1 || cs.stepR2 || cs.stepRun) |=> offX >= $past(offX));
  p_offy_mono_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cs.stepR1 || cs.stepR2 || cs.stepRun) |=> offY <= $past(offY));

endmodule

// File: rtl/ellipse_ctrl.sv
module ellipse_ctrl
  import ellipse_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        pixReady,
  input  dpStatus_t   stat,
  output ctlStrobes_t cs,
  output logic [1:0]  quad,
  output logic        pixValid,
  output logic        done
);
  genState_t state, nextState;
  logic acc, lastQuad, endQuad;

  assign pixValid = (state == S_R1 && stat.r1Active) || state == S_R2 || state == S_RUN;
  assign acc      = pixValid && pixReady;
  assign lastQuad = (quad == 2'd3) || stat.bothZero;

  always_comb begin
    cs        = '0;
    nextState = state;
    endQuad   = 1'b0;
    case (state)
      S_IDLE:   if (start) begin cs.load = 1'b1; nextState = S_QINIT; end
      S_QINIT:  begin cs.quadInit = 1'b1; nextState = stat.ryZero ? S_RUN : S_R1; end
      S_R1: begin
        if (!stat.r1Active) nextState = S_R2INIT;
        else if (acc) cs.stepR1 = 1'b1;
      end
      S_R2INIT: begin cs.r2Init = 1'b1; nextState = S_R2; end
      S_R2:  if (acc) begin if (stat.yZero) endQuad = 1'b1; else cs.stepR2 = 1'b1; end
      S_RUN: if (acc) begin if (stat.xAtRx) endQuad = 1'b1; else cs.stepRun = 1'b1; end
      default: nextState = S_IDLE;
    endcase
    if (endQuad) nextState = lastQuad ? S_IDLE : S_QINIT;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      quad  <= 2'd0;
      done  <= 1'b0;
    end else begin
      state <= nextState;
      if (cs.load) begin
        quad <= 2'd0;
        done <= 1'b0;
      end else if (endQuad) begin
        if (lastQuad) done <= 1'b1;
        else          quad <= quad + 2'd1;
      end
    end
  end

  // R10: no point is offered while done is high
  p_valid_not_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |-> !done);
  // R10: done only rises after an accepted point
  p_done_after_accept_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(acc));

endmodule

// File: rtl/ellipse_outline.sv
module ellipse_outline
  import ellipse_pkg::*;
#(
  parameter int CW   = 12,
  parameter int COLW = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic            circleMode,
  input  logic [CW-1:0]   centerX,
  input  logic [CW-1:0]   centerY,
  input  logic [CW-1:0]   radX,
  input  logic [CW-1:0]   radY,
  input  logic [COLW-1:0] color,
  output logic [CW-1:0]   pixX,
  output logic [CW-1:0]   pixY,
  output logic [COLW-1:0] pixColor,
  output logic            pixValid,
  input  logic            pixReady,
  output logic            done
);
  ctlStrobes_t cs;
  dpStatus_t   stat;
  logic [1:0]  quad;

  ellipse_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .pixReady(pixReady),
    .stat(stat), .cs(cs), .quad(quad), .pixValid(pixValid), .done(done)
  );

  ellipse_dp #(.CW(CW), .COLW(COLW)) u_dp (
    .clk(clk), .rstN(rstN), .cs(cs), .quad(quad), .circleMode(circleMode),
    .centerX(centerX), .centerY(centerY), .radX(radX), .radY(radY),
    .color(color), .stat(stat), .pixX(pixX), .pixY(pixY), .pixColor(pixColor)
  );

  // R7: a stalled point is held
  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && !pixReady) |=> (pixValid && $stable(pixX) && $stable(pixY) && $stable(pixColor)));
  // R9: a start during a run does not disturb the latched colour
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && start) |=> $stable(pixColor));

endmodule

// File: tb/ellipse_outline_tb.sv
module ellipse_outline_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, circleMode = 1'b0, pixReady = 1'b1;
  logic [11:0] centerX = '0, centerY = '0, radX = '0, radY = '0;
  logic [7:0] color = '0;
  logic [11:0] pixX, pixY;
  logic [7:0] pixColor;
  logic pixValid, done;

  int nChecks = 0, nFail = 0;
  int expX[$], expY[$];

  always #5 clk = ~clk;

  ellipse_outline u_dut (
    .clk(clk), .rstN(rstN), .start(start), .circleMode(circleMode),
    .centerX(centerX), .centerY(centerY), .radX(radX), .radY(radY),
    .color(color), .pixX(pixX), .pixY(pixY), .pixColor(pixColor),
    .pixValid(pixValid), .pixReady(pixReady), .done(done)
  );

  task automatic check(bit ok, string req, string what, longint act, longint expv);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Behavioural model of one run: arc offsets, then four quadrant maps
  task automatic buildExpected(int cx, int cy, int rx, int ry);
    int ax[$], ay[$];
    longint x, y, px, py, p, rx2, ry2;
    int nq;
    rx2 = longint'(rx) * rx;
    ry2 = longint'(ry) * ry;
    if (ry == 0) begin
      for (int i = 0; i <= rx; i++) begin ax.push_back(i); ay.push_back(0); end
    end else begin
      x = 0; y = ry; px = 0; py = 2 * rx2 * y;
      p = 4 * ry2 - 4 * rx2 * ry + rx2;
      while (px < py) begin
        ax.push_back(int'(x)); ay.push_back(int'(y));
        x++; px += 2 * ry2;
        if (p < 0) p += 4 * (ry2 + px);
        else begin y--; py -= 2 * rx2; p += 4 * (ry2 + px - py); end
      end
      p = ry2 * (2 * x + 1) * (2 * x + 1) + 4 * rx2 * (y - 1) * (y - 1) - 4 * rx2 * ry2;
      while (y >= 0) begin
        ax.push_back(int'(x)); ay.push_back(int'(y));
        y--; py -= 2 * rx2;
        if (p > 0) p += 4 * (rx2 - py);
        else begin x++; px += 2 * ry2; p += 4 * (rx2 - py + px); end
      end
    end
    nq = (rx == 0 && ry == 0) ? 1 : 4;
    for (int q = 0; q < nq; q++)
      for (int i = 0; i < ax.size(); i++) begin
        expX.push_back(((q % 2) == 1 ? cx + ax[i] : cx - ax[i]) & 12'hFFF);
        expY.push_back((q >= 2 ? cy + ay[i] : cy - ay[i]) & 12'hFFF);
      end
  endtask

  // mode 0: ready high, 1: random ready, 2: start mid-run, 3: start on final accept
  task automatic runShape(int cx, int cy, int rx, int ry, bit circ, int col, int mode, string req);
    int cycles = 0;
    bit prevStall = 1'b0;
    logic [11:0] prevX = '0, prevY = '0;
    bit lateStart = 1'b0;
    buildExpected(cx, cy, rx, circ ? rx : ry);
    @(negedge clk);
    centerX = 12'(cx); centerY = 12'(cy); radX = 12'(rx); radY = 12'(ry);
    circleMode = circ; color = 8'(col); start = 1'b1; pixReady = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0, "R10", "done cleared by start", done, 0);
    while (expX.size() > 0 && cycles < 20000) begin
      @(negedge clk);
      cycles++;
      if (mode == 2 && cycles == 8) begin
        start = 1'b1; centerX = 12'd900; radX = 12'd2; radY = 12'd1;
        color = 8'h5A; circleMode = ~circ;
      end else start = 1'b0;
      pixReady = (mode == 1) ? (($urandom % 4) != 0) : 1'b1;
      if (prevStall) begin
        check(pixValid && pixX == prevX && pixY == prevY, "R7", "held point",
              longint'(pixX) * 4096 + pixY, longint'(prevX) * 4096 + prevY);
      end
      if (pixValid && pixReady) begin
        check(pixX == 12'(expX[0]) && pixY == 12'(expY[0]), req, "point",
              longint'(pixX) * 4096 + pixY, longint'(expX[0]) * 4096 + expY[0]);
        check(pixColor == 8'(col), "R8", "colour", pixColor, col);
        if (mode == 3 && expX.size() == 1) begin
          start = 1'b1; radX = 12'd9; radY = 12'd9; centerX = 12'd50;
          lateStart = 1'b1;
        end
        void'(expX.pop_front()); void'(expY.pop_front());
      end
      prevStall = pixValid && !pixReady;
      prevX = pixX; prevY = pixY;
    end
    check(expX.size() == 0, req, "points left", expX.size(), 0);
    expX.delete(); expY.delete();
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b1 && pixValid == 1'b0, "R10", "done after final accept",
          {done, pixValid}, 2);
    if (lateStart)
      for (int k = 0; k < 5; k++) begin
        @(negedge clk);
        check(pixValid == 1'b0 && done == 1'b1, "R9", "late start ignored", pixValid, 0);
      end
  endtask

  initial begin
    #2000000;
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(pixValid == 1'b0, "R1", "valid in reset", pixValid, 0);
    check(done == 1'b0, "R1", "done in reset", done, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(pixValid == 1'b0 && done == 1'b0, "R1", "idle after reset", {pixValid, done}, 0);

    runShape(200, 150, 7, 4, 1'b0, 8'h11, 0, "R2");
    runShape(300, 300, 3, 12, 1'b0, 8'h22, 1, "R3");
    runShape(400, 100, 6, 2, 1'b1, 8'h33, 1, "R4");
    runShape(50, 60, 5, 0, 1'b0, 8'h44, 0, "R5");
    runShape(70, 80, 0, 3, 1'b0, 8'h45, 1, "R5");
    runShape(90, 90, 0, 0, 1'b0, 8'h66, 0, "R6");
    runShape(2, 4093, 5, 6, 1'b0, 8'h77, 0, "R11");
    runShape(500, 500, 10, 8, 1'b0, 8'h88, 2, "R8");
    runShape(600, 400, 4, 4, 1'b1, 8'h99, 3, "R9");
    runShape(1000, 700, 15, 15, 1'b1, 8'hAA, 1, "R3");

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule